// File: doc/BRIEF.md
# Four-Slot Edge Timestamp Capture

The block keeps a 32-bit free-running up-counter and stores its value into one of four capture slots whenever a chosen edge appears on a single asynchronous input. The slots are filled one after another. Each slot has its own edge polarity. The fill sequence either wraps around continuously or stops after a programmable last slot until software re-arms it.

Every capture and every counter wrap raises a sticky flag. Enabled flags are combined into one interrupt line, and a global pending bit can be dropped without touching the per-event flags. Software reaches the block through a plain 32-bit word-addressed register port. It can read and write the counter and each slot, which lets a saved count be restored before capture resumes.

Top module: `tstamp_capture`

## Requirements
- R1: While control bit 20 (run) is 1 the counter at offset 0x00 rises by exactly one per clock. While it is 0 the counter holds its value.
- R2: A write to offset 0x00 loads the counter with the write data, and counting continues from that value. When run is 1, a read one clock after the write returns the written value plus one.
- R3: When the running counter steps from 0xFFFFFFFF to 0 it sets the overflow flag, which is event 4 at bit 21 of offset 0x2C. The flag is not set in the cycles before the wrap.
- R4: The input passes through a two-flop synchronizer. If the input changes while the counter reads C, the capture slot receives C+2.
- R5: Control bit 2*i selects the edge for slot i: 0 means a rising edge and 1 means a falling edge. An edge of the other direction neither stores a value nor advances the slot sequence.
- R6: Slots are filled in the order 0, 1, 2, 3 up to the last slot set by control bits 18:17. With control bit 16 = 0 (continuous) the next capture after the last slot goes back to slot 0.
- R7: With control bit 16 = 1 (one-shot), edges after the last slot is filled are ignored. Writing control with bit 19 = 1 re-arms the sequence and restarts it at slot 0.
- R8: With control bit 8 (capture enable) at 0, input edges change no slot and set no flag.
- R9: Capture into slot i sets flag bit 17+i of offset 0x2C.
- R10: Offset 0x30 is write-one-to-clear: bit i+1 clears flag i. Zero bits leave the flags unchanged.
- R11: Enable bits 1 to 5 of offset 0x2C gate events 0 to 4. An enabled event sets the global pending bit, which reads at bit 0 of 0x2C. irq_o is 1 while the pending bit is set and some enabled flag is set. Writing bit 0 of 0x30 clears the pending bit and drops irq_o.
- R12: Slot i reads and writes at offset 0x08+4*i. Offset 0x5C reads the ID_VALUE parameter, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cap_i | input | 1 | Asynchronous capture input |
| req_i | input | 1 | Register access valid |
| we_i | input | 1 | Register access is a write |
| addr_i | input | 8 | Byte offset of the word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The main sweep covers every last-slot setting from 0 to 3 against four polarity patterns: all rising, all falling, and the two alternating mixes. Six captures run per setting, so the wrap point of each sequence is crossed. A preparing edge of the wrong direction comes before each capture, which separates correct per-slot polarity from plain toggle detection. All four slots are compared after every capture, so a write to the wrong slot or a missed advance also shows. Separate patterns drive a one-shot run past its last slot and then re-arm it, edges with capture disabled, and a counter preload just below the ceiling to place the wrap cycle exactly. An interrupt sequence with only one event enabled shows that flags of disabled events do not raise the line and that the global clear masks a flag that is still set.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int unsigned DW   = 32;
  localparam int unsigned AW   = 8;
  localparam int unsigned NCAP = 4;
  localparam int unsigned NEVT = NCAP + 1;
  localparam int unsigned PW   = $clog2(NCAP);

  localparam logic [AW-1:0] A_CNT  = 8'h00;
  localparam logic [AW-1:0] A_CAP0 = 8'h08;
  localparam logic [AW-1:0] A_CTRL = 8'h28;
  localparam logic [AW-1:0] A_IEF  = 8'h2C;
  localparam logic [AW-1:0] A_CLR  = 8'h30;
  localparam logic [AW-1:0] A_ID   = 8'h5C;

  localparam int unsigned B_CAPEN   = 8;
  localparam int unsigned B_ONESHOT = 16;
  localparam int unsigned B_STOP_LO = 17;
  localparam int unsigned B_REARM   = 19;
  localparam int unsigned B_RUN     = 20;
  localparam int unsigned B_EN_LO   = 1;
  localparam int unsigned B_FLG_LO  = 17;

  typedef struct packed {
    logic [NCAP-1:0] pol;
    logic            cap_en;
    logic            oneshot;
    logic [PW-1:0]   stop;
    logic            run;
  } ctrl_t;

  function automatic logic [AW-1:0] cap_addr(input int unsigned i);
    return A_CAP0 + AW'(4 * i);
  endfunction
endpackage

// File: rtl/tsc_edge_sync.sv
module tsc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o,
  output logic fall_o
);
  // sr[STAGES-1] is the synchronized level, sr[STAGES] its previous value
  logic [STAGES:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= '0;
    else         sr_q <= {sr_q[STAGES-1:0], d_i};
  end

  assign rise_o =  sr_q[STAGES-1] & ~sr_q[STAGES];
  assign fall_o = ~sr_q[STAGES-1] &  sr_q[STAGES];
endmodule

// File: rtl/tsc_seq.sv
module tsc_seq import tsc_pkg::*; (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            rise_i,
  input  logic            fall_i,
  input  logic [NCAP-1:0] pol_i,
  input  logic            cap_en_i,
  input  logic            oneshot_i,
  input  logic [PW-1:0]   stop_i,
  input  logic            rearm_i,
  output logic [NCAP-1:0] cap_evt_o,
  output logic            armed_o
);
  logic [PW-1:0] ptr_q;
  logic          armed_q;
  logic          hit;

  assign hit = cap_en_i & armed_q & (pol_i[ptr_q] ? fall_i : rise_i);

  for (genvar g = 0; g < NCAP; g++) begin : g_evt
    assign cap_evt_o[g] = hit & (ptr_q == PW'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      armed_q <= 1'b1;
    end else if (rearm_i) begin
      ptr_q   <= '0;
      armed_q <= 1'b1;
    end else if (hit) begin
      if (ptr_q == stop_i) begin
        ptr_q <= '0;
        if (oneshot_i) armed_q <= 1'b0;
      end else begin
        ptr_q <= ptr_q + 1'b1;
      end
    end
  end

  assign armed_o = armed_q;
endmodule

// File: rtl/tsc_irq.sv
module tsc_irq import tsc_pkg::*; (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NEVT-1:0] evt_i,
  input  logic [NEVT-1:0] en_i,
  input  logic            clr_we_i,
  input  logic [NEVT:0]   clr_i,
  output logic [NEVT-1:0] flags_o,
  output logic            gflag_o,
  output logic            irq_o
);
  logic [NEVT-1:0] flags_q;
  logic            gflag_q;
  logic [NEVT-1:0] clr_mask;

  assign clr_mask = clr_we_i ? clr_i[NEVT:1] : '0;

  // a new event wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      gflag_q <= 1'b0;
    end else begin
      flags_q <= (flags_q & ~clr_mask) | evt_i;
      if (|(evt_i & en_i))          gflag_q <= 1'b1;
      else if (clr_we_i && clr_i[0]) gflag_q <= 1'b0;
    end
  end

  assign flags_o = flags_q;
  assign gflag_o = gflag_q;
  assign irq_o   = gflag_q & |(flags_q & en_i);
endmodule

// File: rtl/tstamp_capture.sv
module tstamp_capture import tsc_pkg::*; #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [31:0] ID_VALUE    = 32'h5443_0001
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_o
);
  logic            wr, cnt_wr, ctrl_wr, ief_wr, clr_wr, rearm;
  logic [NCAP-1:0] cap_wr, cap_evt;
  ctrl_t           ctrl_q;
  logic [NEVT-1:0] en_q, flags, evt;
  logic            gflag, armed, ovf_evt;
  logic            cap_rise, cap_fall;
  logic [DW-1:0]   cnt_q;
  logic [DW-1:0]   cap_q [NCAP];
  logic [NCAP*DW-1:0] cap_flat;

  assign wr      = req_i & we_i;
  assign cnt_wr  = wr && (addr_i == A_CNT);
  assign ctrl_wr = wr && (addr_i == A_CTRL);
  assign ief_wr  = wr && (addr_i == A_IEF);
  assign clr_wr  = wr && (addr_i == A_CLR);
  assign rearm   = ctrl_wr & wdata_i[B_REARM];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      for (int i = 0; i < NCAP; i++) ctrl_q.pol[i] <= wdata_i[2*i];
      ctrl_q.cap_en  <= wdata_i[B_CAPEN];
      ctrl_q.oneshot <= wdata_i[B_ONESHOT];
      ctrl_q.stop    <= wdata_i[B_STOP_LO +: PW];
      ctrl_q.run     <= wdata_i[B_RUN];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     en_q <= '0;
    else if (ief_wr) en_q <= wdata_i[B_EN_LO +: NEVT];
  end

  // bus write has priority over counting
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         cnt_q <= '0;
    else if (cnt_wr)     cnt_q <= wdata_i;
    else if (ctrl_q.run) cnt_q <= cnt_q + 1'b1;
  end

  assign ovf_evt = ctrl_q.run & ~cnt_wr & (&cnt_q);

  tsc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (cap_i),
    .rise_o (cap_rise),
    .fall_o (cap_fall)
  );

  tsc_seq u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rise_i    (cap_rise),
    .fall_i    (cap_fall),
    .pol_i     (ctrl_q.pol),
    .cap_en_i  (ctrl_q.cap_en),
    .oneshot_i (ctrl_q.oneshot),
    .stop_i    (ctrl_q.stop),
    .rearm_i   (rearm),
    .cap_evt_o (cap_evt),
    .armed_o   (armed)
  );

  for (genvar g = 0; g < NCAP; g++) begin : g_cap
    assign cap_wr[g] = wr && (addr_i == cap_addr(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         cap_q[g] <= '0;
      else if (cap_wr[g])  cap_q[g] <= wdata_i;
      else if (cap_evt[g]) cap_q[g] <= cnt_q;
    end
    assign cap_flat[g*DW +: DW] = cap_q[g];
  end

  assign evt = {ovf_evt, cap_evt};

  tsc_irq u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt),
    .en_i     (en_q),
    .clr_we_i (clr_wr),
    .clr_i    (wdata_i[NEVT:0]),
    .flags_o  (flags),
    .gflag_o  (gflag),
    .irq_o    (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CNT) rdata_o = cnt_q;
    if (addr_i == A_CTRL) begin
      for (int i = 0; i < NCAP; i++) rdata_o[2*i] = ctrl_q.pol[i];
      rdata_o[B_CAPEN]          = ctrl_q.cap_en;
      rdata_o[B_ONESHOT]        = ctrl_q.oneshot;
      rdata_o[B_STOP_LO +: PW]  = ctrl_q.stop;
      rdata_o[B_RUN]            = ctrl_q.run;
    end
    if (addr_i == A_IEF) begin
      rdata_o[0]                 = gflag;
      rdata_o[B_EN_LO +: NEVT]   = en_q;
      rdata_o[B_FLG_LO +: NEVT]  = flags;
    end
    if (addr_i == A_ID) rdata_o = ID_VALUE;
    for (int i = 0; i < NCAP; i++)
      if (addr_i == cap_addr(i)) rdata_o = cap_q[i];
  end
endmodule

// File: rtl/tsc_checker.sv
module tsc_checker import tsc_pkg::*; (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run_i,
  input logic              cap_en_i,
  input logic              cnt_wr_i,
  input logic [DW-1:0]     cnt_i,
  input logic [NCAP-1:0]   cap_wr_i,
  input logic [NCAP*DW-1:0] caps_i,
  input logic              armed_i,
  input logic              rearm_i,
  input logic [NEVT-1:0]   evt_i,
  input logic [NEVT-1:0]   en_i,
  input logic [NEVT-1:0]   flags_i,
  input logic              clr_wr_i,
  input logic [NEVT:0]     clr_i,
  input logic              irq_o
);
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !cnt_wr_i) |=> $stable(cnt_i)); // R1
  AST_CNT_INC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !cnt_wr_i && cnt_i != '1) |=> (cnt_i == DW'($past(cnt_i) + 1))); // R1
  AST_OVF_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !cnt_wr_i && cnt_i == '1) |=> (flags_i[NCAP] && cnt_i == '0)); // R3
  AST_CAP_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_en_i && cap_wr_i == '0) |=> $stable(caps_i)); // R8
  AST_ONESHOT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_i && !rearm_i && cap_wr_i == '0) |=> $stable(caps_i)); // R7
  AST_FLAG_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr_i && clr_i[1] && !evt_i[0]) |=> !flags_i[0]); // R10
  AST_IRQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_wr_i && clr_i[0] && (evt_i & en_i) == '0) |=> !irq_o); // R11
endmodule

bind tstamp_capture tsc_checker u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .run_i    (ctrl_q.run),
  .cap_en_i (ctrl_q.cap_en),
  .cnt_wr_i (cnt_wr),
  .cnt_i    (cnt_q),
  .cap_wr_i (cap_wr),
  .caps_i   (cap_flat),
  .armed_i  (armed),
  .rearm_i  (rearm),
  .evt_i    (evt),
  .en_i     (en_q),
  .flags_i  (flags),
  .clr_wr_i (clr_wr),
  .clr_i    (wdata_i[tsc_pkg::NEVT:0]),
  .irq_o    (irq_o)
);

// File: tb/tstamp_capture_bench.sv
module tstamp_capture_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap = 1'b0;
  logic        req = 1'b0;
  logic        we = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  logic        lvl = 1'b0;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  localparam logic [31:0] ID = 32'h5443_0001;

  always #2 clk = ~clk;

  tstamp_capture u_tstamp_capture (
    .clk_i (clk), .rst_ni (rst_n), .cap_i (cap), .req_i (req), .we_i (we),
    .addr_i (addr), .wdata_i (wdata), .rdata_o (rdata), .irq_o (irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); req = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); req = 0; we = 0; wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); req = 0; we = 0; addr = a;
    #1 d = rdata;
  endtask

  function automatic logic [31:0] cw(input logic [3:0] pol, input logic capen, input logic one,
                                     input logic [1:0] stop, input logic run, input logic rearm);
    logic [31:0] w = '0;
    for (int i = 0; i < 4; i++) w[2*i] = pol[i];
    w[8] = capen; w[16] = one; w[18:17] = stop; w[19] = rearm; w[20] = run;
    return w;
  endfunction

  // change the input, return counter value seen at the change, settle 3 cycles
  task automatic toggle(input logic v, output logic [31:0] c);
    @(negedge clk); addr = 8'h00; req = 0; cap = v; lvl = v;
    #1 c = rdata;
    repeat (3) @(negedge clk);
  endtask

  // produce the edge slot polarity p asks for; returns expected stored value
  task automatic cap_event(input logic p, output logic [31:0] exp);
    logic [31:0] c;
    if (lvl != p) toggle(p, c);
    toggle(~p, c);
    exp = c + 32'd2;
  endtask

  task automatic check_caps(input string tag, input logic [31:0] e [4]);
    logic [31:0] d;
    for (int i = 0; i < 4; i++) begin
      rd(8'h08 + 8'(4 * i), d);
      chk(tag, d, e[i]);
    end
  endtask

  task automatic zero_caps();
    for (int i = 0; i < 4; i++) wr(8'h08 + 8'(4 * i), 32'h0);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, d2, e;
    logic [31:0] ec [4];
    logic [3:0]  pats [4] = '{4'h0, 4'hF, 4'h5, 4'hA};
    repeat (3) @(negedge clk);
    rst_n = 1;

    // reset state
    rd(8'h00, d); chk("R1 reset counter", d, 0);
    rd(8'h28, d); chk("R1 reset control", d, 0);
    rd(8'h2C, d); chk("R11 reset flags", d, 0);
    chk("R11 reset irq", {31'b0, irq}, 0);

    // R1 hold while stopped
    rd(8'h00, d); repeat (4) @(negedge clk); rd(8'h00, d2);
    chk("R1 hold when stopped", d2, d);

    // R1 counting
    wr(8'h28, cw(4'h0, 1'b1, 1'b0, 2'd3, 1'b1, 1'b1));
    rd(8'h00, d); repeat (4) @(negedge clk); rd(8'h00, d2);
    chk("R1 step per clock", d2, d + 32'd5);

    // R2 preload
    wr(8'h00, 32'h1234_5678); rd(8'h00, d);
    chk("R2 preload", d, 32'h1234_5679);

    // R12 slot write/read, id, unmapped
    wr(8'h0C, 32'hA5A5_0001); rd(8'h0C, d); chk("R12 slot write", d, 32'hA5A5_0001);
    rd(8'h5C, d); chk("R12 id", d, ID);
    rd(8'h04, d); chk("R12 unmapped", d, 0);
    rd(8'h28, d); chk("R12 control readback", d, cw(4'h0, 1'b1, 1'b0, 2'd3, 1'b1, 1'b0));

    // R3 overflow
    wr(8'h30, 32'h3F);
    wr(8'h00, 32'hFFFF_FFFD);
    rd(8'h2C, d); chk("R3 no flag before wrap", {31'b0, d[21]}, 0);
    rd(8'h2C, d); chk("R3 no flag at ceiling", {31'b0, d[21]}, 0);
    rd(8'h00, d); chk("R3 wrap to zero", d, 0);
    rd(8'h2C, d); chk("R3 overflow flag", {31'b0, d[21]}, 1);
    wr(8'h30, 32'h20);
    rd(8'h2C, d); chk("R10 clear overflow flag", {31'b0, d[21]}, 0);

    // R4 R5 R6 R9 sweep: last slot x polarity pattern
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 4; p++) begin
        int ptr;
        zero_caps();
        wr(8'h30, 32'h3F);
        wr(8'h28, cw(pats[p], 1'b1, 1'b0, 2'(s), 1'b1, 1'b1));
        for (int i = 0; i < 4; i++) ec[i] = 0;
        ptr = 0;
        for (int n = 0; n < 6; n++) begin
          cap_event(pats[p][ptr], e);
          ec[ptr] = e;
          check_caps($sformatf("R4 R5 R6 stop=%0d pol=%h n=%0d", s, pats[p], n), ec);
          rd(8'h2C, d);
          chk("R9 slot flag", {31'b0, d[17 + ptr]}, 1);
          wr(8'h30, 32'h3F);
          ptr = (ptr == s) ? 0 : ptr + 1;
        end
      end
    end

    // R8 capture disabled
    zero_caps(); wr(8'h30, 32'h3F);
    wr(8'h28, cw(4'h0, 1'b0, 1'b0, 2'd3, 1'b1, 1'b1));
    cap_event(1'b0, e); cap_event(1'b0, e);
    for (int i = 0; i < 4; i++) ec[i] = 0;
    check_caps("R8 disabled no store", ec);
    rd(8'h2C, d); chk("R8 disabled no flag", d[21:17], 0);

    // R7 one-shot, last slot 1
    wr(8'h28, cw(4'h0, 1'b1, 1'b1, 2'd1, 1'b1, 1'b1));
    cap_event(1'b0, ec[0]);
    cap_event(1'b0, ec[1]);
    cap_event(1'b0, e);
    check_caps("R7 one-shot blocks", ec);
    rd(8'h2C, d); chk("R7 one-shot flags", d[21:17], 5'b00011);
    wr(8'h28, cw(4'h0, 1'b1, 1'b1, 2'd1, 1'b1, 1'b1));
    cap_event(1'b0, ec[0]);
    check_caps("R7 re-arm restarts at slot 0", ec);
    wr(8'h30, 32'h3F);

    // R10 R11 interrupt, only event 2 enabled
    wr(8'h2C, 32'h8);
    wr(8'h28, cw(4'h0, 1'b1, 1'b0, 2'd3, 1'b1, 1'b1));
    cap_event(1'b0, e); chk("R11 disabled slot0 no irq", {31'b0, irq}, 0);
    cap_event(1'b0, e); chk("R11 disabled slot1 no irq", {31'b0, irq}, 0);
    cap_event(1'b0, e); chk("R11 enabled slot2 irq", {31'b0, irq}, 1);
    rd(8'h2C, d); chk("R11 pending bit", {31'b0, d[0]}, 1);
    wr(8'h30, 32'h0);
    rd(8'h2C, d); chk("R10 zero write keeps flags", d[21:17], 5'b00111);
    wr(8'h30, 32'h1);
    chk("R11 global clear drops irq", {31'b0, irq}, 0);
    rd(8'h2C, d); chk("R11 flag survives global clear", {31'b0, d[19]}, 1);
    cap_event(1'b0, e); chk("R11 disabled slot3 no irq", {31'b0, irq}, 0);
    wr(8'h30, 32'h8);
    rd(8'h2C, d); chk("R10 clear only flag 2", d[21:17], 5'b01011);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule